// File: doc/BRIEF.md
# Bidirectional Byte-Wide I/O Port with Pull-Up Control

This block is a general-purpose I/O port of up to eight pins, controlled over a small byte-wide register bus. Three per-pin registers hold the output value, the pin direction and a pull-up request. Each pin is set to input or output on its own. A read of the value register returns a mixed word. For a pin set to output, the bit comes from the output latch. For a pin set to input, the bit is the pin level after synchronisation. Writing back a word that was just read therefore copies the levels seen on input pins into their latches.

The pad side of the block has three outputs: a drive value, an output enable and a pull-up request. A pull-up is requested only when the pin is an input, its pull-up bit is set, and the chip-level stop-mode signal is low. A mask parameter names the pins that exist. Pins outside the mask ignore writes, read as zero, and never drive or pull.

A two-state access machine handles reads. In state BUS_IDLE, a read strobe captures the addressed word and moves the machine to BUS_RESP. In BUS_RESP the valid flag is high for one cycle. The machine then returns to BUS_IDLE, or stays in BUS_RESP if another strobe arrives. Writes take effect at the clock edge on which the write strobe is sampled.

Top module: `bidir_io_port`

## Requirements
- R1: After reset, the direction, output-latch and pull-up registers are all zero, so pin_oe, pin_out, pin_pullup and bus_rvalid are all 0.
- R2: The value register is at address 0, the direction register at 1 and the pull-up register at 2. A direction bit of 1 makes that pin an output (pin_oe=1) and 0 makes it an input. pin_oe changes only after a direction write.
- R3: A read of address 0 returns, per bit, the output latch when the direction bit is 1 and the synchronised pin level when it is 0. Reads of addresses 1 and 2 return the direction and pull-up registers.
- R4: A write to address 0 updates the output latch of every implemented bit, whatever its direction. pin_out shows the latch, but it drives the pin only through pin_oe. pin_out changes only after a write to address 0.
- R5: pin_pullup for a bit is 1 exactly when its pull-up bit is 1, its direction bit is 0 and stop_mode is 0.
- R6: While stop_mode is 1, all pin_pullup bits are 0.
- R7: Reading address 0 and writing the same word back loads the current pin levels into the latches of input bits and leaves the latches of output bits unchanged.
- R8: Bits outside IMPL_MASK ignore writes and read as 0. Their pin_oe, pin_out and pin_pullup stay 0.
- R9: A change on pin_in first appears in a read whose strobe is sampled at the third rising edge after the change, which is a two-flop lag.
- R10: Read data and bus_rvalid=1 appear in the cycle after the read strobe. bus_rvalid is 0 in any cycle not preceded by a read strobe.
- R11: The output latch resets to 0. If the value is written before the direction bit is set, pin_out is already at that value when pin_oe rises, so the pin shows no glitch.
- R12: Writes to address 3 change no register, and reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response flag |
| stop_mode | input | 1 | Chip stop mode; suppresses pull-ups |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Output latch value to the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pullup | output | 8 | Per-pin pull-up request |

## Verification
The assertions assume that bus_we and bus_re are never high in the same cycle. They also assume that pin_out and pin_oe can change only through a write strobe, so no other path may disturb them. The bench drives every strobe from tasks that raise a single strobe for exactly one cycle at the falling edge, and it holds pin_in and stop_mode steady for at least three cycles before it reads back a value.

// File: rtl/bidir_io_pkg.sv
package bidir_io_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_VALUE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DIR   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PULL  = 2'd2;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_t;
endpackage

// File: rtl/bidir_io_sync.sv
module bidir_io_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/bidir_io_cell.sv
module bidir_io_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic we_value,
    input  logic we_dir,
    input  logic we_pull,
    input  logic wbit,
    input  logic pin_sync,
    input  logic stop_mode,
    output logic rd_value,
    output logic rd_dir,
    output logic rd_pull,
    output logic drv,
    output logic oe,
    output logic pu
);
    logic latch_q, dir_q, pull_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
            dir_q   <= 1'b0;
            pull_q  <= 1'b0;
        end else begin
            if (we_value) latch_q <= wbit;
            if (we_dir)   dir_q   <= wbit;
            if (we_pull)  pull_q  <= wbit;
        end
    end

    always_comb begin
        rd_value = dir_q ? latch_q : pin_sync;
        rd_dir   = dir_q;
        rd_pull  = pull_q;
        drv      = latch_q;
        oe       = dir_q;
        pu       = pull_q & ~dir_q & ~stop_mode;
    end
endmodule

// File: rtl/bidir_io_bus.sv
module bidir_io_bus
    import bidir_io_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic [WIDTH-1:0] rd_word,
    output logic [WIDTH-1:0] rdata,
    output logic             rvalid
);
    bus_state_t state_q, state_d;

    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = rd_stb ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_stb ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_stb) rdata <= rd_word;
    end

    assign rvalid = (state_q == BUS_RESP);
endmodule

// File: rtl/bidir_io_port.sv
module bidir_io_port
    import bidir_io_pkg::*;
#(
    parameter int               WIDTH       = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] IMPL_MASK   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic              stop_mode,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_pullup
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] rd_value, rd_dir, rd_pull;
    logic [WIDTH-1:0] rd_word;
    logic             we_value, we_dir, we_pull;

    assign we_value = bus_we && (bus_addr == ADDR_VALUE);
    assign we_dir   = bus_we && (bus_addr == ADDR_DIR);
    assign we_pull  = bus_we && (bus_addr == ADDR_PULL);

    bidir_io_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            bidir_io_cell cell_i (
                .clk(clk), .rst_n(rst_n),
                .we_value(we_value), .we_dir(we_dir), .we_pull(we_pull),
                .wbit(bus_wdata[i]), .pin_sync(pin_sync[i]), .stop_mode(stop_mode),
                .rd_value(rd_value[i]), .rd_dir(rd_dir[i]), .rd_pull(rd_pull[i]),
                .drv(pin_out[i]), .oe(pin_oe[i]), .pu(pin_pullup[i])
            );
        end else begin : g_absent
            assign rd_value[i]   = 1'b0;
            assign rd_dir[i]     = 1'b0;
            assign rd_pull[i]    = 1'b0;
            assign pin_out[i]    = 1'b0;
            assign pin_oe[i]     = 1'b0;
            assign pin_pullup[i] = 1'b0;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_VALUE: rd_word = rd_value;
            ADDR_DIR:   rd_word = rd_dir;
            ADDR_PULL:  rd_word = rd_pull;
            default:    rd_word = '0;
        endcase
    end

    bidir_io_bus #(.WIDTH(WIDTH)) bus_i (
        .clk(clk), .rst_n(rst_n), .rd_stb(bus_re), .rd_word(rd_word),
        .rdata(bus_rdata), .rvalid(bus_rvalid)
    );
endmodule

// File: rtl/bidir_io_port_chk.sv
module bidir_io_port_chk #(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] IMPL_MASK = 8'hFF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic             bus_re,
    input logic             bus_rvalid,
    input logic             stop_mode,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] pin_pullup
);
    assert_no_pull_on_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pullup & pin_oe) == '0);

    assert_stop_kills_pull_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |-> (pin_pullup == '0));

    assert_read_response_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> bus_rvalid);

    assert_no_stray_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> !bus_rvalid);

    assert_oe_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pin_oe));

    assert_out_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pin_out));

    assert_absent_bits_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out | pin_oe | pin_pullup) & ~IMPL_MASK) == '0);
endmodule

bind bidir_io_port bidir_io_port_chk #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rvalid(bus_rvalid), .stop_mode(stop_mode), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_pullup(pin_pullup)
);

// File: tb/bidir_io_port_tb_top.sv
module bidir_io_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0, bus_re = 1'b0, stop_mode = 1'b0;
    logic [7:0] pin_in = '0;
    logic [7:0] bus_rdata, pin_out, pin_oe, pin_pullup;
    logic       bus_rvalid;
    logic [7:0] n_rdata, n_out, n_oe, n_pu;
    logic       n_rvalid;
    int         n_checks = 0, n_fail = 0;
    logic [7:0] rd_main, rd_narrow;
    logic       rv_main;

    always #2ns clk = ~clk;

    bidir_io_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .stop_mode(stop_mode), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pullup(pin_pullup)
    );

    bidir_io_port #(.IMPL_MASK(8'h1F)) dut_narrow_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(n_rdata), .bus_rvalid(n_rvalid),
        .stop_mode(stop_mode), .pin_in(pin_in), .pin_out(n_out), .pin_oe(n_oe),
        .pin_pullup(n_pu)
    );

    // Each entry: dir, written value, pins, pull, stop, exp read, exp oe, exp pullup
    localparam logic [63:0] VECS [4] = '{
        {8'h00, 8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h3C, 8'h00, 8'hFF},
        {8'hFF, 8'hA5, 8'h3C, 8'hFF, 8'h00, 8'hA5, 8'hFF, 8'h00},
        {8'hF0, 8'h5A, 8'h0F, 8'h33, 8'h00, 8'h5F, 8'hF0, 8'h03},
        {8'h0F, 8'hC3, 8'h99, 8'hFF, 8'h01, 8'h93, 8'h0F, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_re = 1'b0;
        rd_main = bus_rdata; rd_narrow = n_rdata; rv_main = bus_rvalid;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(4ns * 100000);
        n_fail++;
        $display("FAIL watchdog R10 actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 oe", pin_oe, 8'h00);
        check("R1 out", pin_out, 8'h00);
        check("R1 pullup", pin_pullup, 8'h00);
        check("R1 rvalid", {7'd0, bus_rvalid}, 8'h00);
        bus_read(2'd1);
        check("R1 dir reads zero", rd_main, 8'h00);
        idle(1);
        check("R10 valid drops", {7'd0, bus_rvalid}, 8'h00);

        // R11 latch resets to zero: output before any write drives low
        bus_write(2'd1, 8'h01);
        check("R11 oe bit0", pin_oe, 8'h01);
        check("R11 out low", pin_out, 8'h00);
        bus_write(2'd1, 8'h00);

        // table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < 4; v++) begin
            bus_write(2'd2, VECS[v][39:32]);
            bus_write(2'd1, VECS[v][63:56]);
            bus_write(2'd0, VECS[v][55:48]);
            pin_in = VECS[v][47:40];
            stop_mode = VECS[v][24];
            idle(3);
            bus_read(2'd0);
            check("R3 read mix", rd_main, VECS[v][23:16]);
            check("R10 rvalid", {7'd0, rv_main}, 8'h01);
            check("R2 oe", pin_oe, VECS[v][15:8]);
            check("R4 out", pin_out, VECS[v][55:48]);
            check(VECS[v][24] ? "R6 pullup in stop" : "R5 pullup", pin_pullup, VECS[v][7:0]);
        end
        stop_mode = 1'b0;
        bus_read(2'd2);
        check("R3 pull readback", rd_main, 8'hFF);
        bus_read(2'd1);
        check("R3 dir readback", rd_main, 8'h0F);

        // R12 address 3
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3);
        check("R12 addr3 read", rd_main, 8'h00);
        bus_read(2'd1);
        check("R12 dir untouched", rd_main, 8'h0F);

        // R7 read-modify-write
        bus_write(2'd0, 8'h00);
        pin_in = 8'hA5;
        idle(3);
        bus_read(2'd0);
        check("R7 read", rd_main, 8'hA0);
        bus_write(2'd0, rd_main);
        bus_write(2'd1, 8'hFF);
        check("R7 latch after writeback", pin_out, 8'hA0);

        // R9 synchroniser lag
        bus_write(2'd1, 8'h00);
        pin_in = 8'h00;
        idle(3);
        pin_in = 8'h81;
        bus_read(2'd0);
        check("R9 first edge old", rd_main, 8'h00);
        bus_read(2'd0);
        check("R9 second edge old", rd_main, 8'h00);
        bus_read(2'd0);
        check("R9 third edge new", rd_main, 8'h81);

        // R11 write value before direction: no glitch
        bus_write(2'd0, 8'h04);
        check("R11 value before oe", {pin_oe[2], pin_out[2]}, 8'h01);
        bus_write(2'd1, 8'h04);
        check("R11 clean rise", {pin_oe[2], pin_out[2]}, 8'h03);

        // R8 narrow port
        bus_write(2'd2, 8'hFF);
        bus_write(2'd1, 8'hFF);
        bus_write(2'd0, 8'hFF);
        check("R8 narrow oe", n_oe, 8'h1F);
        check("R8 narrow out", n_out, 8'h1F);
        bus_read(2'd1);
        check("R8 narrow dir read", rd_narrow, 8'h1F);
        bus_write(2'd1, 8'h00);
        check("R8 narrow pullup", n_pu, 8'h1F);
        pin_in = 8'hFF;
        idle(3);
        bus_read(2'd0);
        check("R8 narrow value read", rd_narrow, 8'h1F);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule